// File: doc/BRIEF.md
# Cache Slice Load Sequencer

This block models the cache-slice end of a load on a ring fabric that carries separate request, acknowledge and data channels. A core's load enters a small in-order queue together with a hit/miss indication that stands in for the tag lookup. For a hit, the slice answers the requesting core with a completion packet followed by the line split into half-line data beats. For a miss, the slice passes the request on to the system agent as new request traffic and tells the core, with one acknowledge packet, that the request has been taken.

A built-in system-agent model holds each forwarded miss for a fixed memory latency. It then sends the requesting core its own completion and data beats directly. After that it sends a data-only copy of the line back to the slice, which keeps the shared cache inclusive. Every packet leaves as a descriptor carrying ring type, destination, lane, requester id, tag and beat index. The slice port and the system-agent port are separate outputs and may both be active in the same cycle.

Top module: `slice_load_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it is released, neither packet port is valid and `req_ready` is 1.
- R2: A hit accepted at clock edge E drives the slice port with an acknowledge-ring packet (ring code 1) to the core (destination code 0) in the cycle after edge E+1. Data-ring packets (ring code 2) with beat 0 and beat 1 follow in the next two cycles. Every packet echoes the request's core id, tag and lane.
- R3: A miss accepted at edge E drives the slice port with a request-ring packet (ring code 0) to the system agent (destination code 1) on the lane the request came in on, in the cycle after edge E+1. One acknowledge-ring packet to the core follows in the next cycle. The slice port never carries data for a miss.
- R4: The system agent emits its first packet for a miss exactly MEM_LAT+2 cycles after the slice forwarded it, unless an earlier delivery is still running. That packet is an acknowledge to the core. Core data beats 0 and 1 follow, then slice data beats 0 and 1 (destination code 2), in five consecutive cycles. All of them echo core, tag and lane. The slice never receives an acknowledge.
- R5: The request queue holds Q_DEPTH entries, and `req_ready` is 0 while it is full. A request offered while `req_ready` is 0 is not taken and produces no packet.
- R6: Responses leave in the order requests were accepted. A new request starts in the cycle right after the previous one's last slice packet, with no idle cycle. System-agent deliveries keep forwarding order.
- R7: At most SA_DEPTH misses are outstanding at the system agent. The forward of miss k+SA_DEPTH is not emitted until the delivery of miss k has sent its last packet, and later requests wait behind it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load request offered |
| req_ready | output | 1 | Queue can take a request this cycle |
| req_core | input | CORE_W | Requesting core id |
| req_tag | input | TAG_W | Transaction tag |
| req_lane | input | 1 | Request lane the load arrived on |
| req_hit | input | 1 | 1 = line present in the slice |
| sl_vld | output | 1 | Slice packet valid |
| sl_ring | output | 2 | Slice packet ring: 0 request, 1 acknowledge, 2 data |
| sl_dst | output | 2 | Slice packet destination: 0 core, 1 system agent, 2 slice |
| sl_lane | output | 1 | Slice packet lane |
| sl_core | output | CORE_W | Requester id echoed |
| sl_tag | output | TAG_W | Tag echoed |
| sl_beat | output | BEAT_W | Data beat index (0 for non-data) |
| sa_vld | output | 1 | System-agent packet valid |
| sa_ring | output | 2 | System-agent packet ring |
| sa_dst | output | 2 | System-agent packet destination |
| sa_lane | output | 1 | System-agent packet lane |
| sa_core | output | CORE_W | Requester id echoed |
| sa_tag | output | TAG_W | Tag echoed |
| sa_beat | output | BEAT_W | Data beat index |

## Verification
Two things can happen in the same cycle: the slice serving a later hit, and the system agent delivering an earlier miss's line, with both ports valid and sometimes aimed at the same core. The mixed back-to-back scenario places hits right after a miss, so the miss's delivery window, MEM_LAT+2 cycles after its forward, overlaps those hits. Each port's stream is then compared on its own against exact expected cycles, so a packet dropped or delayed because the other port was busy is caught. A second overlap comes from six misses in a row: the credit freed by a finishing delivery and the forwarding of a waiting miss land on the same clock edge, and this is judged by forward spacing against delivery ends.

// File: rtl/slq_pkg.sv
`timescale 1ns/1ps
package slq_pkg;
  // ring channel carried by a packet
  typedef enum logic [1:0] {
    RING_REQ  = 2'd0,
    RING_ACK  = 2'd1,
    RING_DATA = 2'd2
  } ring_e;

  // destination class of a packet
  typedef enum logic [1:0] {
    DST_CORE  = 2'd0,
    DST_SYSAG = 2'd1,
    DST_SLICE = 2'd2
  } dst_e;
endpackage

// File: rtl/slq_fifo.sv
`timescale 1ns/1ps
module slq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, wr_ptr_n, rd_ptr, rd_ptr_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             do_push, do_pop;

  assign full  = (cnt == CNT_W'(DEPTH));
  assign empty = (cnt == '0);
  assign dout  = mem[rd_ptr];

  always_comb begin
    do_push  = push && !full;
    do_pop   = pop && !empty;
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    cnt_n    = cnt;
    if (do_push) begin
      wr_ptr_n = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
    end
    if (do_pop) begin
      rd_ptr_n = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
    end
    if (do_push && !do_pop) cnt_n = cnt + CNT_W'(1);
    if (do_pop && !do_push) cnt_n = cnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      cnt    <= cnt_n;
    end
  end

  // storage: no reset, written only under its enable
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end
endmodule

// File: rtl/slq_slice_seq.sv
`timescale 1ns/1ps
module slq_slice_seq
  import slq_pkg::*;
#(
  parameter int CORE_W   = 3,
  parameter int TAG_W    = 4,
  parameter int BEATS    = 2,
  parameter int BEAT_W   = 1,
  parameter int SA_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              q_empty,
  input  logic [CORE_W-1:0] q_core,
  input  logic [TAG_W-1:0]  q_tag,
  input  logic              q_lane,
  input  logic              q_hit,
  output logic              q_pop,
  input  logic              sa_done,
  output logic              p_vld,
  output logic [1:0]        p_ring,
  output logic [1:0]        p_dst,
  output logic              p_lane,
  output logic [CORE_W-1:0] p_core,
  output logic [TAG_W-1:0]  p_tag,
  output logic [BEAT_W-1:0] p_beat
);
  localparam int CR_W = $clog2(SA_DEPTH + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_GO, ST_DATA, ST_FWD, ST_MACK
  } st_e;

  st_e               state, state_n;
  logic [CORE_W-1:0] cur_core, cur_core_n;
  logic [TAG_W-1:0]  cur_tag, cur_tag_n;
  logic              cur_lane, cur_lane_n;
  logic [BEAT_W-1:0] beat, beat_n;
  logic [CR_W-1:0]   credits, credits_n;
  logic              at_end, can_take;

  always_comb begin
    at_end   = (state == ST_IDLE) || (state == ST_MACK) ||
               ((state == ST_DATA) && (beat == BEAT_W'(BEATS - 1)));
    can_take = !q_empty && (q_hit || (credits < CR_W'(SA_DEPTH)));
    q_pop    = at_end && can_take;

    state_n    = state;
    beat_n     = beat;
    cur_core_n = cur_core;
    cur_tag_n  = cur_tag;
    cur_lane_n = cur_lane;

    if (at_end) begin
      if (q_pop) begin
        state_n    = q_hit ? ST_GO : ST_FWD;
        cur_core_n = q_core;
        cur_tag_n  = q_tag;
        cur_lane_n = q_lane;
      end else begin
        state_n = ST_IDLE;
      end
    end else begin
      unique case (state)
        ST_GO: begin
          state_n = ST_DATA;
          beat_n  = '0;
        end
        ST_DATA: beat_n  = beat + BEAT_W'(1);
        ST_FWD:  state_n = ST_MACK;
        default: state_n = ST_IDLE;
      endcase
    end

    credits_n = credits;
    if (q_pop && !q_hit && !sa_done) credits_n = credits + CR_W'(1);
    if (sa_done && !(q_pop && !q_hit)) credits_n = credits - CR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      beat    <= '0;
      credits <= '0;
    end else begin
      state   <= state_n;
      beat    <= beat_n;
      credits <= credits_n;
    end
  end

  // request context: loaded only when a request is taken
  always_ff @(posedge clk) begin
    if (q_pop) begin
      cur_core <= cur_core_n;
      cur_tag  <= cur_tag_n;
      cur_lane <= cur_lane_n;
    end
  end

  always_comb begin
    p_vld  = (state != ST_IDLE);
    p_ring = RING_ACK;
    p_dst  = DST_CORE;
    p_beat = '0;
    unique case (state)
      ST_DATA: begin
        p_ring = RING_DATA;
        p_beat = beat;
      end
      ST_FWD: begin
        p_ring = RING_REQ;
        p_dst  = DST_SYSAG;
      end
      default: ;
    endcase
    p_lane = cur_lane;
    p_core = cur_core;
    p_tag  = cur_tag;
  end
endmodule

// File: rtl/slq_sa_model.sv
`timescale 1ns/1ps
module slq_sa_model
  import slq_pkg::*;
#(
  parameter int CORE_W   = 3,
  parameter int TAG_W    = 4,
  parameter int BEATS    = 2,
  parameter int BEAT_W   = 1,
  parameter int MEM_LAT  = 6,
  parameter int SA_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwd_vld,
  input  logic [CORE_W-1:0] fwd_core,
  input  logic [TAG_W-1:0]  fwd_tag,
  input  logic              fwd_lane,
  output logic              done,
  output logic              p_vld,
  output logic [1:0]        p_ring,
  output logic [1:0]        p_dst,
  output logic              p_lane,
  output logic [CORE_W-1:0] p_core,
  output logic [TAG_W-1:0]  p_tag,
  output logic [BEAT_W-1:0] p_beat
);
  localparam int PW = CORE_W + TAG_W + 1;

  typedef enum logic [1:0] {
    SA_IDLE, SA_GO, SA_CDATA, SA_SDATA
  } sa_st_e;

  // fixed-latency memory stand-in
  logic          dl_vld [MEM_LAT];
  logic [PW-1:0] dl_pay [MEM_LAT];

  for (genvar k = 0; k < MEM_LAT; k++) begin : g_stage
    logic          in_vld;
    logic [PW-1:0] in_pay;
    if (k == 0) begin : g_head
      assign in_vld = fwd_vld;
      assign in_pay = {fwd_core, fwd_tag, fwd_lane};
    end else begin : g_tail
      assign in_vld = dl_vld[k-1];
      assign in_pay = dl_pay[k-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dl_vld[k] <= 1'b0;
      else        dl_vld[k] <= in_vld;
    end
    always_ff @(posedge clk) begin
      if (in_vld) dl_pay[k] <= in_pay;
    end
  end

  logic          rq_pop, rq_full, rq_empty;
  logic [PW-1:0] rq_dout;

  slq_fifo #(.W(PW), .DEPTH(SA_DEPTH)) u_ret_q (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (dl_vld[MEM_LAT-1]),
    .din   (dl_pay[MEM_LAT-1]),
    .pop   (rq_pop),
    .dout  (rq_dout),
    .full  (rq_full),
    .empty (rq_empty)
  );

  sa_st_e        state, state_n;
  logic [BEAT_W-1:0] beat, beat_n;
  logic [PW-1:0] cur, cur_n;
  logic          at_end, beat_last;

  always_comb begin
    beat_last = (beat == BEAT_W'(BEATS - 1));
    at_end    = (state == SA_IDLE) || ((state == SA_SDATA) && beat_last);
    rq_pop    = at_end && !rq_empty;
    done      = (state == SA_SDATA) && beat_last;
    state_n   = state;
    beat_n    = beat;
    cur_n     = cur;
    if (at_end) begin
      if (rq_pop) begin
        state_n = SA_GO;
        cur_n   = rq_dout;
      end else begin
        state_n = SA_IDLE;
      end
    end else begin
      unique case (state)
        SA_GO: begin
          state_n = SA_CDATA;
          beat_n  = '0;
        end
        SA_CDATA: begin
          if (beat_last) begin
            state_n = SA_SDATA;
            beat_n  = '0;
          end else begin
            beat_n = beat + BEAT_W'(1);
          end
        end
        default: beat_n = beat + BEAT_W'(1);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SA_IDLE;
      beat  <= '0;
    end else begin
      state <= state_n;
      beat  <= beat_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rq_pop) cur <= cur_n;
  end

  always_comb begin
    p_vld  = (state != SA_IDLE);
    p_ring = (state == SA_GO) ? RING_ACK : RING_DATA;
    p_dst  = (state == SA_SDATA) ? DST_SLICE : DST_CORE;
    p_beat = (state == SA_GO) ? '0 : beat;
    {p_core, p_tag, p_lane} = cur;
  end
endmodule

// File: rtl/slice_load_sequencer.sv
`timescale 1ns/1ps
module slice_load_sequencer
  import slq_pkg::*;
#(
  parameter int N_CORES    = 8,
  parameter int TAG_W      = 4,
  parameter int LINE_BYTES = 64,
  parameter int BEAT_BYTES = 32,
  parameter int Q_DEPTH    = 4,
  parameter int MEM_LAT    = 6,
  parameter int SA_DEPTH   = 4,
  localparam int CORE_W    = $clog2(N_CORES),
  localparam int BEATS     = LINE_BYTES / BEAT_BYTES,
  localparam int BEAT_W    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CORE_W-1:0] req_core,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic              req_lane,
  input  logic              req_hit,
  output logic              sl_vld,
  output logic [1:0]        sl_ring,
  output logic [1:0]        sl_dst,
  output logic              sl_lane,
  output logic [CORE_W-1:0] sl_core,
  output logic [TAG_W-1:0]  sl_tag,
  output logic [BEAT_W-1:0] sl_beat,
  output logic              sa_vld,
  output logic [1:0]        sa_ring,
  output logic [1:0]        sa_dst,
  output logic              sa_lane,
  output logic [CORE_W-1:0] sa_core,
  output logic [TAG_W-1:0]  sa_tag,
  output logic [BEAT_W-1:0] sa_beat
);
  localparam int QW = CORE_W + TAG_W + 2;

  logic          q_full, q_empty, q_pop;
  logic [QW-1:0] q_dout;
  logic [CORE_W-1:0] h_core;
  logic [TAG_W-1:0]  h_tag;
  logic          h_lane, h_hit;
  logic          sa_done, fwd_vld;

  assign req_ready = !q_full;
  assign {h_core, h_tag, h_lane, h_hit} = q_dout;

  slq_fifo #(.W(QW), .DEPTH(Q_DEPTH)) u_req_q (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (req_valid),
    .din   ({req_core, req_tag, req_lane, req_hit}),
    .pop   (q_pop),
    .dout  (q_dout),
    .full  (q_full),
    .empty (q_empty)
  );

  slq_slice_seq #(
    .CORE_W(CORE_W), .TAG_W(TAG_W), .BEATS(BEATS),
    .BEAT_W(BEAT_W), .SA_DEPTH(SA_DEPTH)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .q_empty (q_empty),
    .q_core  (h_core),
    .q_tag   (h_tag),
    .q_lane  (h_lane),
    .q_hit   (h_hit),
    .q_pop   (q_pop),
    .sa_done (sa_done),
    .p_vld   (sl_vld),
    .p_ring  (sl_ring),
    .p_dst   (sl_dst),
    .p_lane  (sl_lane),
    .p_core  (sl_core),
    .p_tag   (sl_tag),
    .p_beat  (sl_beat)
  );

  // forwarded misses travel to the system agent on the slice port
  assign fwd_vld = sl_vld && (sl_ring == RING_REQ) && (sl_dst == DST_SYSAG);

  slq_sa_model #(
    .CORE_W(CORE_W), .TAG_W(TAG_W), .BEATS(BEATS), .BEAT_W(BEAT_W),
    .MEM_LAT(MEM_LAT), .SA_DEPTH(SA_DEPTH)
  ) u_sa (
    .clk      (clk),
    .rst_n    (rst_n),
    .fwd_vld  (fwd_vld),
    .fwd_core (sl_core),
    .fwd_tag  (sl_tag),
    .fwd_lane (sl_lane),
    .done     (sa_done),
    .p_vld    (sa_vld),
    .p_ring   (sa_ring),
    .p_dst    (sa_dst),
    .p_lane   (sa_lane),
    .p_core   (sa_core),
    .p_tag    (sa_tag),
    .p_beat   (sa_beat)
  );
endmodule

// File: rtl/slice_load_sequencer_chk.sv
`timescale 1ns/1ps
module slice_load_sequencer_chk
  import slq_pkg::*;
#(
  parameter int CORE_W = 3,
  parameter int TAG_W  = 4,
  parameter int BEATS  = 2,
  parameter int BEAT_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              sl_vld,
  input logic [1:0]        sl_ring,
  input logic [1:0]        sl_dst,
  input logic              sl_lane,
  input logic [CORE_W-1:0] sl_core,
  input logic [TAG_W-1:0]  sl_tag,
  input logic [BEAT_W-1:0] sl_beat,
  input logic              sa_vld,
  input logic [1:0]        sa_ring,
  input logic [1:0]        sa_dst,
  input logic [BEAT_W-1:0] sa_beat,
  input logic [TAG_W-1:0]  sa_tag
);
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sl_vld && !sa_vld && req_ready));

  p_data_beats_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sl_vld && sl_ring == RING_DATA && sl_beat != BEAT_W'(BEATS - 1)) |=>
    (sl_vld && sl_ring == RING_DATA && sl_beat == $past(sl_beat) + BEAT_W'(1)
     && $stable(sl_tag) && $stable(sl_core) && $stable(sl_lane)));

  p_fwd_to_agent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sl_vld && sl_ring == RING_REQ) |-> (sl_dst == DST_SYSAG));

  p_fwd_then_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sl_vld && sl_ring == RING_REQ) |=>
    (sl_vld && sl_ring == RING_ACK && sl_dst == DST_CORE
     && $stable(sl_tag) && $stable(sl_lane)));

  p_slice_gets_data_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sa_vld && sa_dst == DST_SLICE) |-> (sa_ring == RING_DATA));

  p_copy_follows_core_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sa_vld && sa_ring == RING_DATA && sa_dst == DST_CORE
     && sa_beat == BEAT_W'(BEATS - 1)) |=>
    (sa_vld && sa_dst == DST_SLICE && sa_beat == '0 && $stable(sa_tag)));
endmodule

bind slice_load_sequencer slice_load_sequencer_chk #(
  .CORE_W(CORE_W), .TAG_W(TAG_W), .BEATS(BEATS), .BEAT_W(BEAT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .sl_vld    (sl_vld),
  .sl_ring   (sl_ring),
  .sl_dst    (sl_dst),
  .sl_lane   (sl_lane),
  .sl_core   (sl_core),
  .sl_tag    (sl_tag),
  .sl_beat   (sl_beat),
  .sa_vld    (sa_vld),
  .sa_ring   (sa_ring),
  .sa_dst    (sa_dst),
  .sa_beat   (sa_beat),
  .sa_tag    (sa_tag)
);

// File: tb/slice_load_sequencer_bench.sv
`timescale 1ns/1ps
module slice_load_sequencer_bench;
  localparam int N_CORES = 8, TAG_W = 4, Q_DEPTH = 4, MEM_LAT = 6, SA_DEPTH = 4;
  localparam int CORE_W = 3, BEATS = 2, BEAT_W = 1;
  localparam int RG_REQ = 0, RG_ACK = 1, RG_DATA = 2;
  localparam int DS_CORE = 0, DS_SA = 1, DS_SLICE = 2;

  logic clk, rst_n, req_valid, req_ready, req_lane, req_hit;
  logic [CORE_W-1:0] req_core;
  logic [TAG_W-1:0]  req_tag;
  logic sl_vld, sl_lane, sa_vld, sa_lane;
  logic [1:0] sl_ring, sl_dst, sa_ring, sa_dst;
  logic [CORE_W-1:0] sl_core, sa_core;
  logic [TAG_W-1:0]  sl_tag, sa_tag;
  logic [BEAT_W-1:0] sl_beat, sa_beat;

  slice_load_sequencer #(
    .N_CORES(N_CORES), .TAG_W(TAG_W), .Q_DEPTH(Q_DEPTH),
    .MEM_LAT(MEM_LAT), .SA_DEPTH(SA_DEPTH)
  ) u_slice_load_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_core(req_core), .req_tag(req_tag), .req_lane(req_lane), .req_hit(req_hit),
    .sl_vld(sl_vld), .sl_ring(sl_ring), .sl_dst(sl_dst), .sl_lane(sl_lane),
    .sl_core(sl_core), .sl_tag(sl_tag), .sl_beat(sl_beat),
    .sa_vld(sa_vld), .sa_ring(sa_ring), .sa_dst(sa_dst), .sa_lane(sa_lane),
    .sa_core(sa_core), .sa_tag(sa_tag), .sa_beat(sa_beat)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {int st; int ring; int dst; int lane; int core; int tag; int beat;} pk_t;
  pk_t sl_log [512];
  pk_t sa_log [512];
  int  n_sl, n_sa, cyc, ready_lo, checks, fails;
  int  rq_core [64], rq_tag [64], rq_lane [64], rq_hit [64], rq_acc [64];
  int  n_rq;

  always @(posedge clk) cyc = cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!req_ready) ready_lo = ready_lo + 1;
      if (sl_vld && n_sl < 512) begin
        sl_log[n_sl] = '{cyc, int'(sl_ring), int'(sl_dst), int'(sl_lane),
                         int'(sl_core), int'(sl_tag), int'(sl_beat)};
        n_sl = n_sl + 1;
      end
      if (sa_vld && n_sa < 512) begin
        sa_log[n_sa] = '{cyc, int'(sa_ring), int'(sa_dst), int'(sa_lane),
                         int'(sa_core), int'(sa_tag), int'(sa_beat)};
        n_sa = n_sa + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input string act, input string exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%s expected=%s", rq, act, exp);
    end
  endtask

  function automatic string ps(pk_t p);
    return $sformatf("[t%0d ring%0d dst%0d lane%0d core%0d tag%0d beat%0d]",
                     p.st, p.ring, p.dst, p.lane, p.core, p.tag, p.beat);
  endfunction

  function automatic pk_t mk(int st, int ring, int dst, int i, int beat);
    pk_t p;
    p = '{st, ring, dst, rq_lane[i], rq_core[i], rq_tag[i], beat};
    return p;
  endfunction

  function automatic bit same(pk_t a, pk_t b);
    return a.st == b.st && a.ring == b.ring && a.dst == b.dst && a.lane == b.lane
        && a.core == b.core && a.tag == b.tag && a.beat == b.beat;
  endfunction

  task automatic cmp(input bit sa_side, input int idx, input pk_t e, input string rq);
    if (sa_side) begin
      if (idx >= n_sa) chk(1'b0, rq, "none", ps(e));
      else chk(same(sa_log[idx], e), rq, ps(sa_log[idx]), ps(e));
    end else begin
      if (idx >= n_sl) chk(1'b0, rq, "none", ps(e));
      else chk(same(sl_log[idx], e), rq, ps(sl_log[idx]), ps(e));
    end
  endtask

  task automatic clear_logs();
    n_sl = 0; n_sa = 0; n_rq = 0; ready_lo = 0;
  endtask

  task automatic send(input int core, input int tag, input int lane, input int hit);
    @(negedge clk);
    req_valid = 1'b1;
    req_core  = CORE_W'(core);
    req_tag   = TAG_W'(tag);
    req_lane  = lane[0];
    req_hit   = hit[0];
    while (!req_ready) @(negedge clk);
    rq_core[n_rq] = core; rq_tag[n_rq] = tag; rq_lane[n_rq] = lane;
    rq_hit[n_rq] = hit;   rq_acc[n_rq] = cyc + 1;
    n_rq = n_rq + 1;
  endtask

  task automatic stop_driving();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Builds the expected streams of both ports from the accepted requests.
  task automatic verify(input bit timed, input string rs, input string ra);
    int s, p, nm, prev, st, i;
    int fwd [64];
    int mreq [64];
    int salast [64];
    s = 0; nm = 0; prev = -1000;
    for (int r = 0; r < n_rq; r++) begin
      if (timed) st = (rq_acc[r] + 1 > prev + 1) ? rq_acc[r] + 1 : prev + 1;
      else st = (s < n_sl) ? sl_log[s].st : -1;
      if (rq_hit[r] != 0) begin
        cmp(1'b0, s, mk(st, RG_ACK, DS_CORE, r, 0), rs); s++;
        for (int b = 0; b < BEATS; b++) begin
          cmp(1'b0, s, mk(st + 1 + b, RG_DATA, DS_CORE, r, b), rs); s++;
        end
        prev = st + BEATS;
      end else begin
        cmp(1'b0, s, mk(st, RG_REQ, DS_SA, r, 0), rs);
        fwd[nm] = (s < n_sl) ? sl_log[s].st : st;
        mreq[nm] = r; nm++; s++;
        cmp(1'b0, s, mk(st + 1, RG_ACK, DS_CORE, r, 0), rs); s++;
        prev = st + 1;
      end
    end
    chk(n_sl == s, rs, $sformatf("%0d slice packets", n_sl), $sformatf("%0d", s));
    p = 0; prev = -1000;
    for (int m = 0; m < nm; m++) begin
      i  = mreq[m];
      st = (fwd[m] + MEM_LAT + 2 > prev + 1) ? fwd[m] + MEM_LAT + 2 : prev + 1;
      cmp(1'b1, p, mk(st, RG_ACK, DS_CORE, i, 0), ra); p++;
      for (int b = 0; b < BEATS; b++) begin
        cmp(1'b1, p, mk(st + 1 + b, RG_DATA, DS_CORE, i, b), ra); p++;
      end
      for (int b = 0; b < BEATS; b++) begin
        cmp(1'b1, p, mk(st + 1 + BEATS + b, RG_DATA, DS_SLICE, i, b), ra); p++;
      end
      prev = st + 2 * BEATS;
      salast[m] = prev;
    end
    chk(n_sa == p, ra, $sformatf("%0d agent packets", n_sa), $sformatf("%0d", p));
    if (!timed) begin
      for (int m = SA_DEPTH; m < nm; m++) begin
        // R7: forward of miss m waits for delivery m-SA_DEPTH to end
        chk(fwd[m] > salast[m - SA_DEPTH], "R7",
            $sformatf("fwd t%0d", fwd[m]), $sformatf("after t%0d", salast[m - SA_DEPTH]));
      end
    end
  endtask

  task automatic t_reset();
    clear_logs();
    chk(req_ready == 1'b1, "R1", $sformatf("ready=%0b", req_ready), "ready=1");
    repeat (5) @(negedge clk);
    chk(n_sl == 0 && n_sa == 0, "R1",
        $sformatf("sl=%0d sa=%0d", n_sl, n_sa), "sl=0 sa=0");
  endtask

  task automatic t_hits();
    clear_logs();
    send(5, 9, 1, 1);
    stop_driving();
    repeat (10) @(negedge clk);
    send(2, 3, 0, 1);
    stop_driving();
    repeat (10) @(negedge clk);
    verify(1'b1, "R2", "R2");
  endtask

  task automatic t_miss();
    clear_logs();
    send(3, 4, 1, 0);
    stop_driving();
    repeat (MEM_LAT + 20) @(negedge clk);
    send(6, 12, 0, 0);
    stop_driving();
    repeat (MEM_LAT + 20) @(negedge clk);
    verify(1'b1, "R3", "R4");
  endtask

  task automatic t_mixed();
    clear_logs();
    send(1, 1, 0, 1);
    send(4, 2, 1, 0);
    send(4, 3, 1, 1);
    send(7, 4, 0, 1);
    send(0, 5, 1, 0);
    send(2, 6, 0, 1);
    send(4, 7, 0, 1);
    stop_driving();
    repeat (MEM_LAT + 40) @(negedge clk);
    verify(1'b1, "R6", "R6");
  endtask

  task automatic t_full();
    bit offered;
    int ghost_pk;
    clear_logs();
    for (int k = 0; k < 8; k++) send(k, k, k % 2, 1);
    stop_driving();
    offered = 1'b0;
    for (int w = 0; w < 12 && !offered; w++) begin
      if (!req_ready) begin
        req_valid = 1'b1; req_core = 3'd7; req_tag = 4'd15; req_lane = 1'b1; req_hit = 1'b1;
        offered = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    chk(offered && ready_lo > 0, "R5", $sformatf("ready low %0d cycles", ready_lo), ">0");
    repeat (40) @(negedge clk);
    verify(1'b1, "R5", "R5");
    ghost_pk = 0;
    for (int k = 0; k < n_sl; k++) if (sl_log[k].tag == 15) ghost_pk++;
    chk(ghost_pk == 0, "R5", $sformatf("%0d packets for refused tag", ghost_pk), "0");
    chk(req_ready == 1'b1, "R5", $sformatf("ready=%0b", req_ready), "ready=1 after drain");
  endtask

  task automatic t_credits();
    clear_logs();
    for (int k = 0; k < SA_DEPTH + 2; k++) send(k, k + 8, (k + 1) % 2, 0);
    send(3, 2, 1, 1);
    stop_driving();
    repeat (MEM_LAT + 80) @(negedge clk);
    verify(1'b0, "R7", "R7");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks = checks + 1;
    fails  = fails + 1;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0; cyc = 0; n_sl = 0; n_sa = 0; n_rq = 0; ready_lo = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_core = '0; req_tag = '0;
    req_lane = 1'b0; req_hit = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_hits();
    t_miss();
    t_mixed();
    t_full();
    t_credits();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule